// File: doc/BRIEF.md
# Block Storage Controller Register Bank

This block is the memory-mapped target side of a DMA block-storage controller. Software programs a memory buffer base address, a block count and the index of the first block through a window of eight 32-bit registers. It then writes an opcode to start a transfer. The block passes those parameters to a separate transfer engine and signals the start with a one-cycle go pulse that carries the direction. It tracks the engine's progress in a status register and raises a level interrupt when the transfer finishes.

The register bus has one beat per access. A request is taken on any clock edge where `busValid` is high. Exactly one response follows on the next cycle, with read data or an error flag. The engine reports completion by pulsing `engDone`, with `engFail` giving the outcome. A status read in a finished state returns the result code, clears the state back to idle and removes the interrupt. Transfer parameters cannot be changed while a transfer or an unread result is pending.

Top module: `blkdev_regbank`

## Requirements
- R1: After reset the buffer base, block count and first-block registers read 0. Interrupt enable reads 1, status reads 0 (idle), and `irq` and `engGo` are low.
- R2: Word offsets 0x00 (buffer base), 0x04 (block count), 0x08 (first block) and 0x14 (interrupt enable) can be read and written. Any non-zero write to 0x14 reads back as 1, and a zero write reads back as 0. Every request gets exactly one response, with `rspValid` high in the cycle after the request.
- R3: Offset 0x18 reads the parameter DEV_BLOCKS (default 65536). Offset 0x1C reads the parameter BLOCK_BYTES (default 512).
- R4: An access gets an error response (`rspErr`=1, `rspData`=0) and changes no state in these cases:
  - a write to 0x10, 0x18 or 0x1C;
  - a read of 0x0C;
  - an address whose two low bits are not zero;
  - an address at or above 0x20.
- R5: A write of 1 (read from storage) or 2 (write to storage) to 0x0C while idle sets status to 1 (busy). In the following cycle it raises `engGo` for exactly one cycle, and `engRead` is 1 for code 1 and 0 for code 2. Any other value is a no-op: no go pulse, and status stays idle.
- R6: While busy, an `engDone` pulse sets status as follows:
  - 2 for a successful read;
  - 3 for a successful write;
  - 4 for a failed read (`engFail`=1);
  - 5 for a failed write.
  `engDone` has no effect in any other state.
- R7: `irq` is high exactly when status is 2, 3, 4 or 5 and interrupt enable is 1.
- R8: A read of the status register (0x10) returns the current code. When that code is 2 to 5, status returns to 0 on the next cycle and `irq` drops. A status read while idle or busy changes nothing.
- R9: Writes to 0x00, 0x04, 0x08 and 0x0C are silently ignored (no error) while status is not idle. Writes to interrupt enable are always accepted.
- R10: `engBufBase`, `engBlkCount` and `engFirstBlk` always show the buffer base, block count and first-block registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the access |
| busWdata | input | 32 | Write data |
| rspValid | output | 1 | Response present (one cycle after request) |
| rspData | output | 32 | Read data (0 on writes and errors) |
| rspErr | output | 1 | Error response |
| engDone | input | 1 | Transfer engine finished (pulse) |
| engFail | input | 1 | Finished transfer failed (valid with engDone) |
| engGo | output | 1 | One-cycle start pulse to the engine |
| engRead | output | 1 | Latched direction: 1 = storage to memory |
| engBufBase | output | 32 | Memory buffer base address |
| engBlkCount | output | 32 | Number of blocks to move |
| engFirstBlk | output | 32 | Index of the first block |
| irq | output | 1 | Level interrupt |

## Verification
Both directions are run through success and failure completions. This separates all four terminal codes and shows that the latched direction, not the opcode last written, picks the code. Status is read repeatedly in the idle, busy and terminal states, which tells the clear-on-read effect apart from a plain read. Parameter and opcode writes are attempted while busy and while a result is unread, then read back, to tell a dropped write from an accepted one. The interrupt is observed with enable set and cleared. Error traffic covers each forbidden kind of access, with read-back afterwards to show nothing changed.

// File: rtl/blkdev_regbank_pkg.sv
package blkdev_regbank_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_BUSY   = 3'd1,
    ST_RD_OK  = 3'd2,
    ST_WR_OK  = 3'd3,
    ST_RD_ERR = 3'd4,
    ST_WR_ERR = 3'd5
  } devStatus_e;

  localparam int unsigned NUM_REGS   = 8;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WIN_BITS   = $clog2(NUM_REGS * WORD_BYTES);
  localparam int unsigned IDX_W      = $clog2(NUM_REGS);

  localparam logic [IDX_W-1:0] IDX_BUF   = 3'd0;
  localparam logic [IDX_W-1:0] IDX_CNT   = 3'd1;
  localparam logic [IDX_W-1:0] IDX_FIRST = 3'd2;
  localparam logic [IDX_W-1:0] IDX_OP    = 3'd3;
  localparam logic [IDX_W-1:0] IDX_STAT  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_IRQEN = 3'd5;
  localparam logic [IDX_W-1:0] IDX_SIZE  = 3'd6;
  localparam logic [IDX_W-1:0] IDX_BSIZE = 3'd7;

  localparam logic [31:0] OPC_READ  = 32'd1;
  localparam logic [31:0] OPC_WRITE = 32'd2;

  // strobes from the control to the datapath
  typedef struct packed {
    logic             access;
    logic             rdEn;
    logic             rspErr;
    logic             wrBuf;
    logic             wrCnt;
    logic             wrFirst;
    logic             wrIrqEn;
    logic [IDX_W-1:0] rdSel;
  } regStrobes_t;

endpackage

// File: rtl/blkdev_regbank_ctrl.sv
module blkdev_regbank_ctrl
  import blkdev_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              engDone,
  input  logic              engFail,
  output regStrobes_t       strb,
  output devStatus_e        status,
  output logic              go,
  output logic              goRead
);

  logic             inWindow;
  logic             aligned;
  logic [IDX_W-1:0] idx;
  logic             isIdle;
  logic             isTerminal;
  logic             startRead;
  logic             startWrite;
  logic             clrStatus;
  devStatus_e       statusNext;

  assign inWindow   = (busAddr[ADDR_W-1:WIN_BITS] == '0);
  assign aligned    = (busAddr[1:0] == 2'b00);
  assign idx        = busAddr[WIN_BITS-1:2];
  assign isIdle     = (status == ST_IDLE);
  assign isTerminal = (status == ST_RD_OK) || (status == ST_WR_OK) ||
                      (status == ST_RD_ERR) || (status == ST_WR_ERR);

  always_comb begin
    strb        = '0;
    strb.access = busValid;
    strb.rdSel  = idx;
    startRead   = 1'b0;
    startWrite  = 1'b0;
    clrStatus   = 1'b0;
    if (busValid) begin
      if (!inWindow || !aligned) begin
        strb.rspErr = 1'b1;
      end else if (busWrite) begin
        unique case (idx)
          IDX_BUF:   strb.wrBuf   = isIdle;
          IDX_CNT:   strb.wrCnt   = isIdle;
          IDX_FIRST: strb.wrFirst = isIdle;
          IDX_IRQEN: strb.wrIrqEn = 1'b1;
          IDX_OP: begin
            startRead  = isIdle && (busWdata == OPC_READ);
            startWrite = isIdle && (busWdata == OPC_WRITE);
          end
          default:   strb.rspErr  = 1'b1;
        endcase
      end else begin
        if (idx == IDX_OP) begin
          strb.rspErr = 1'b1;
        end else begin
          strb.rdEn = 1'b1;
          clrStatus = (idx == IDX_STAT) && isTerminal;
        end
      end
    end
  end

  always_comb begin
    statusNext = status;
    unique case (status)
      ST_IDLE: if (startRead || startWrite) statusNext = ST_BUSY;
      ST_BUSY: if (engDone) begin
        if (goRead) statusNext = engFail ? ST_RD_ERR : ST_RD_OK;
        else        statusNext = engFail ? ST_WR_ERR : ST_WR_OK;
      end
      default: if (clrStatus) statusNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= ST_IDLE;
      go     <= 1'b0;
      goRead <= 1'b0;
    end else begin
      status <= statusNext;
      go     <= startRead || startWrite;
      if (startRead || startWrite) goRead <= startRead;
    end
  end

  AST_GO_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    go |=> !go);  // R5
  AST_GO_WITH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    go |-> (status == ST_BUSY));  // R5
  AST_DONE_LEAVES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_BUSY && engDone) |=> (status != ST_BUSY && status != ST_IDLE));  // R6
  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    clrStatus |=> (status == ST_IDLE));  // R8
  AST_STATUS_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    status <= ST_WR_ERR);  // R6

endmodule

// File: rtl/blkdev_regbank_dp.sv
module blkdev_regbank_dp
  import blkdev_regbank_pkg::*;
#(
  parameter logic [31:0] DEV_BLOCKS  = 32'd65536,
  parameter logic [31:0] BLOCK_BYTES = 32'd512
) (
  input  logic        clk,
  input  logic        rstN,
  input  regStrobes_t strb,
  input  logic [31:0] busWdata,
  input  devStatus_e  status,
  output logic [31:0] bufBase,
  output logic [31:0] blkCount,
  output logic [31:0] firstBlk,
  output logic        irq,
  output logic        rspValid,
  output logic [31:0] rspData,
  output logic        rspErr
);

  logic        irqEn;
  logic [31:0] rdMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufBase  <= '0;
      blkCount <= '0;
      firstBlk <= '0;
      irqEn    <= 1'b1;
    end else begin
      if (strb.wrBuf)   bufBase  <= busWdata;
      if (strb.wrCnt)   blkCount <= busWdata;
      if (strb.wrFirst) firstBlk <= busWdata;
      if (strb.wrIrqEn) irqEn    <= (busWdata != '0);
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      IDX_BUF:   rdMux = bufBase;
      IDX_CNT:   rdMux = blkCount;
      IDX_FIRST: rdMux = firstBlk;
      IDX_STAT:  rdMux = {29'd0, status};
      IDX_IRQEN: rdMux = {31'd0, irqEn};
      IDX_SIZE:  rdMux = DEV_BLOCKS;
      IDX_BSIZE: rdMux = BLOCK_BYTES;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.access;
      rspErr   <= strb.rspErr;
      rspData  <= strb.rdEn ? rdMux : '0;
    end
  end

  assign irq = irqEn && (status != ST_IDLE) && (status != ST_BUSY);

  AST_PARAMS_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (status != ST_IDLE) |=> ($stable(bufBase) && $stable(blkCount) && $stable(firstBlk)));  // R9
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);  // R4
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspData == '0));  // R4

endmodule

// File: rtl/blkdev_regbank.sv
module blkdev_regbank
  import blkdev_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter logic [31:0] DEV_BLOCKS  = 32'd65536,
  parameter logic [31:0] BLOCK_BYTES = 32'd512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              rspValid,
  output logic [31:0]       rspData,
  output logic              rspErr,
  input  logic              engDone,
  input  logic              engFail,
  output logic              engGo,
  output logic              engRead,
  output logic [31:0]       engBufBase,
  output logic [31:0]       engBlkCount,
  output logic [31:0]       engFirstBlk,
  output logic              irq
);

  regStrobes_t strb;
  devStatus_e  status;

  blkdev_regbank_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .engDone  (engDone),
    .engFail  (engFail),
    .strb     (strb),
    .status   (status),
    .go       (engGo),
    .goRead   (engRead)
  );

  blkdev_regbank_dp #(.DEV_BLOCKS(DEV_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .status   (status),
    .bufBase  (engBufBase),
    .blkCount (engBlkCount),
    .firstBlk (engFirstBlk),
    .irq      (irq),
    .rspValid (rspValid),
    .rspData  (rspData),
    .rspErr   (rspErr)
  );

  AST_IRQ_ONLY_TERMINAL: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (status >= ST_RD_OK));  // R7
  AST_GO_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    engGo |-> ($past(status) == ST_IDLE));  // R5

endmodule

// File: tb/blkdev_regbank_test.sv
module blkdev_regbank_test;

  localparam int unsigned ADDR_W = 12;
  localparam logic [31:0] DEV_BLOCKS  = 32'd65536;
  localparam logic [31:0] BLOCK_BYTES = 32'd512;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busValid = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic              rspValid;
  logic [31:0]       rspData;
  logic              rspErr;
  logic              engDone = 1'b0;
  logic              engFail = 1'b0;
  logic              engGo;
  logic              engRead;
  logic [31:0]       engBufBase;
  logic [31:0]       engBlkCount;
  logic [31:0]       engFirstBlk;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  blkdev_regbank #(.ADDR_W(ADDR_W), .DEV_BLOCKS(DEV_BLOCKS), .BLOCK_BYTES(BLOCK_BYTES)) uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .rspValid(rspValid),
    .rspData(rspData), .rspErr(rspErr), .engDone(engDone), .engFail(engFail),
    .engGo(engGo), .engRead(engRead), .engBufBase(engBufBase),
    .engBlkCount(engBlkCount), .engFirstBlk(engFirstBlk), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per response
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected response", rspData, 32'd0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(rspErr == it.err, {it.tag, " err"}, {31'd0, rspErr}, {31'd0, it.err});
        check(rspData == it.data, {it.tag, " data"}, rspData, it.data);
      end
    end
  end

  // driver: one request cycle, returns at the negedge after the accepting edge
  task automatic access(input bit wr, input logic [ADDR_W-1:0] addr, input logic [31:0] wdata,
                        input logic [31:0] expData, input bit expErr, input string tag);
    expItem_t it;
    it.data = expData;
    it.err  = expErr;
    it.tag  = tag;
    expQ.push_back(it);
    busValid = 1'b1;
    busWrite = wr;
    busAddr  = addr;
    busWdata = wdata;
    @(negedge clk);
    busValid = 1'b0;
    busWrite = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] addr, input logic [31:0] d, input bit expErr, input string tag);
    access(1'b1, addr, d, 32'd0, expErr, tag);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] addr, input logic [31:0] expData, input bit expErr, input string tag);
    access(1'b0, addr, 32'd0, expData, expErr, tag);
  endtask

  task automatic finishEngine(input bit fail);
    engDone = 1'b1;
    engFail = fail;
    @(negedge clk);
    engDone = 1'b0;
    engFail = 1'b0;
  endtask

  // start an operation and check the go pulse
  task automatic startOp(input logic [31:0] code, input bit expRead, input string tag);
    wr(12'h00C, code, 1'b0, tag);
    check(engGo == 1'b1, {tag, " go high"}, {31'd0, engGo}, 32'd1);
    check(engRead == expRead, {tag, " direction"}, {31'd0, engRead}, {31'd0, expRead});
    @(negedge clk);
    check(engGo == 1'b0, {tag, " go one cycle"}, {31'd0, engGo}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(irq == 1'b0, "R1 irq after reset", {31'd0, irq}, 32'd0);
    check(engGo == 1'b0, "R1 go after reset", {31'd0, engGo}, 32'd0);
    rd(12'h000, 32'd0, 1'b0, "R1 buffer reset");
    rd(12'h004, 32'd0, 1'b0, "R1 count reset");
    rd(12'h008, 32'd0, 1'b0, "R1 first reset");
    rd(12'h014, 32'd1, 1'b0, "R1 irq enable reset");
    rd(12'h010, 32'd0, 1'b0, "R1 status reset");

    // R2 / R10 read-write registers
    wr(12'h000, 32'h8000_1000, 1'b0, "R2 write buffer");
    wr(12'h004, 32'd4, 1'b0, "R2 write count");
    wr(12'h008, 32'h0000_0020, 1'b0, "R2 write first");
    rd(12'h000, 32'h8000_1000, 1'b0, "R2 read buffer");
    rd(12'h004, 32'd4, 1'b0, "R2 read count");
    rd(12'h008, 32'h0000_0020, 1'b0, "R2 read first");
    check(engBufBase == 32'h8000_1000, "R10 buffer out", engBufBase, 32'h8000_1000);
    check(engBlkCount == 32'd4, "R10 count out", engBlkCount, 32'd4);
    check(engFirstBlk == 32'h20, "R10 first out", engFirstBlk, 32'h20);
    wr(12'h014, 32'd0, 1'b0, "R2 irq enable clear");
    rd(12'h014, 32'd0, 1'b0, "R2 irq enable reads 0");
    wr(12'h014, 32'd5, 1'b0, "R2 irq enable nonzero");
    rd(12'h014, 32'd1, 1'b0, "R2 irq enable reads 1");

    // R3 read-only constants
    rd(12'h018, DEV_BLOCKS, 1'b0, "R3 capacity");
    rd(12'h01C, BLOCK_BYTES, 1'b0, "R3 block size");

    // R4 error responses
    wr(12'h010, 32'd3, 1'b1, "R4 write status");
    wr(12'h018, 32'd9, 1'b1, "R4 write capacity");
    wr(12'h01C, 32'd9, 1'b1, "R4 write block size");
    rd(12'h00C, 32'd0, 1'b1, "R4 read opcode");
    rd(12'h020, 32'd0, 1'b1, "R4 read outside window");
    wr(12'h020, 32'd7, 1'b1, "R4 write outside aliased buffer");
    wr(12'h001, 32'd7, 1'b1, "R4 misaligned write");
    rd(12'h000, 32'h8000_1000, 1'b0, "R4 buffer unchanged");
    rd(12'h010, 32'd0, 1'b0, "R4 status unchanged");
    rd(12'h018, DEV_BLOCKS, 1'b0, "R4 capacity unchanged");

    // R5 no-op codes
    wr(12'h00C, 32'd0, 1'b0, "R5 noop write");
    check(engGo == 1'b0, "R5 noop no go", {31'd0, engGo}, 32'd0);
    wr(12'h00C, 32'd7, 1'b0, "R5 unknown code");
    check(engGo == 1'b0, "R5 unknown no go", {31'd0, engGo}, 32'd0);
    rd(12'h010, 32'd0, 1'b0, "R5 status still idle");

    // R6 done while idle has no effect
    finishEngine(1'b0);
    rd(12'h010, 32'd0, 1'b0, "R6 done while idle ignored");

    // read transfer, success
    startOp(32'd1, 1'b1, "R5 start read");
    rd(12'h010, 32'd1, 1'b0, "R5 status busy");
    rd(12'h010, 32'd1, 1'b0, "R8 busy read keeps busy");
    check(irq == 1'b0, "R7 irq low while busy", {31'd0, irq}, 32'd0);
    wr(12'h000, 32'h0000_1234, 1'b0, "R9 buffer write while busy");
    rd(12'h000, 32'h8000_1000, 1'b0, "R9 buffer kept while busy");
    wr(12'h00C, 32'd2, 1'b0, "R9 opcode while busy");
    check(engGo == 1'b0, "R9 no go while busy", {31'd0, engGo}, 32'd0);
    finishEngine(1'b0);
    check(irq == 1'b1, "R7 irq on read success", {31'd0, irq}, 32'd1);
    wr(12'h004, 32'd99, 1'b0, "R9 count write while terminal");
    rd(12'h004, 32'd4, 1'b0, "R9 count kept while terminal");
    check(engBlkCount == 32'd4, "R10 count out kept", engBlkCount, 32'd4);
    rd(12'h010, 32'd2, 1'b0, "R6 read success code");
    check(irq == 1'b0, "R8 irq dropped after status read", {31'd0, irq}, 32'd0);
    rd(12'h010, 32'd0, 1'b0, "R8 status cleared to idle");

    // write transfer, failure
    startOp(32'd2, 1'b0, "R5 start write");
    finishEngine(1'b1);
    check(irq == 1'b1, "R7 irq on write error", {31'd0, irq}, 32'd1);
    rd(12'h010, 32'd5, 1'b0, "R6 write error code");
    rd(12'h010, 32'd0, 1'b0, "R8 cleared after write error");

    // read failure with interrupt disabled
    wr(12'h014, 32'd0, 1'b0, "R9 irq enable write accepted");
    startOp(32'd1, 1'b1, "R5 start read again");
    finishEngine(1'b1);
    check(irq == 1'b0, "R7 irq masked when disabled", {31'd0, irq}, 32'd0);
    wr(12'h014, 32'd1, 1'b0, "R9 irq enable in terminal");
    check(irq == 1'b1, "R7 irq after enabling", {31'd0, irq}, 32'd1);
    rd(12'h010, 32'd4, 1'b0, "R6 read error code");
    check(irq == 1'b0, "R8 irq dropped again", {31'd0, irq}, 32'd0);

    // write success, parameters writable again once idle
    wr(12'h008, 32'd77, 1'b0, "R9 first write when idle");
    rd(12'h008, 32'd77, 1'b0, "R9 first accepted when idle");
    startOp(32'd2, 1'b0, "R5 start write again");
    finishEngine(1'b0);
    rd(12'h010, 32'd3, 1'b0, "R6 write success code");
    rd(12'h010, 32'd0, 1'b0, "R8 idle after write success");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2 all responses seen", expQ.size(), 32'd0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule